// File: doc/BRIEF.md
# Multicycle Long-Call Sequencer

The block is a small multicycle datapath with its own control unit that fetches and executes one four-byte long subroutine call. It holds a 16-bit program counter, memory address register, instruction register and stack pointer, plus an 8-bit memory data register and a single-ported file of 32 byte registers. All of these exchange values over one 16-bit internal bus, and each microoperation makes exactly one transfer on that bus or one byte access to memory.

A `start_i` pulse loads the program counter and stack pointer from the start inputs. The controller then reads the four instruction bytes through the address and data registers. The two opcode bytes go into the instruction register. The two target bytes are parked in scratch registers R1 (high) and R0 (low). The controller checks the opcode, pushes the return address one byte at a time, and finally copies the target from the scratch registers into the program counter. The whole sequence takes exactly 20 microoperations. If the opcode is wrong, the controller halts with an illegal-instruction flag raised and leaves the stack untouched.

Top module: `call_seq_core`

## Requirements
- R1: After reset `busy_o`, `done_o` and `illegal_o` are 0, `uop_cnt_o` is 0, and `pc_o` and `sp_o` are 0.
- R2: The instruction is read as four single-byte reads at addresses P, P+1, P+2 and P+3 (modulo 2^16), in that order, where P is `start_pc_i`. The byte at P is the opcode high byte, then come the opcode low byte, the target high byte and the target low byte.
- R3: The opcode must equal 16'h940E. If it differs, `illegal_o` goes to 1 on the clock edge of the 7th microoperation (7 cycles after the start edge) and `busy_o` goes to 0. Memory is not written and `sp_o` keeps its start value. A later start clears `illegal_o`.
- R4: The return address is P+4. Its low byte is written at address S (`start_sp_i`) and its high byte at S-1 (modulo 2^16), low byte first.
- R5: When the call completes, `sp_o` equals S-2 modulo 2^16.
- R6: When `done_o` is 1, `pc_o` equals the target, which is {third byte, fourth byte}.
- R7: `done_o` is a single-cycle pulse. It is high during the cycle that follows the 20th clock edge after the start edge.
- R8: `uop_cnt_o` counts completed microoperations. It is 0 after a start, reads 20 while `done_o` is high, and never exceeds 20.
- R9: `start_i` is ignored while `busy_o` is 1. A running call completes with the same results.
- R10: In any cycle at most one of `mem_re_o` and `mem_we_o` is 1, and exactly two memory writes occur per successful call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a call sequence (when not busy) |
| start_pc_i | input | 16 | Instruction address loaded at start |
| start_sp_i | input | 16 | Stack pointer loaded at start |
| mem_addr_o | output | 16 | Byte address (memory address register) |
| mem_re_o | output | 1 | Byte read strobe; data taken at the clock edge |
| mem_we_o | output | 1 | Byte write strobe |
| mem_wdata_o | output | 8 | Write data (memory data register) |
| mem_rdata_i | input | 8 | Read data for `mem_addr_o` |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Opcode mismatch, held until the next start |
| uop_cnt_o | output | 5 | Completed microoperation count |

## Verification
The bench places calls at addresses where P+1 to P+3 wrap past 16'hFFFF, and uses a stack pointer of 0 so the second push lands at 16'hFFFF. A design that carries the byte increment wrongly, or decrements the stack pointer in the wrong width, writes the return bytes to the wrong place or reads the wrong target. The bench tests opcodes that differ in a single bit and opcodes whose high byte matches but whose low byte does not. A design that compares only one byte, or checks the opcode too late, would push onto the stack or move the stack pointer. A start pulse in the middle of a run would restart a design that does not guard against it, so the done pulse would arrive late or with a count other than 20.

// File: rtl/call_seq_pkg.sv
package call_seq_pkg;
  parameter int unsigned DATA_W   = 8;
  parameter int unsigned ADDR_W   = 2 * DATA_W;
  parameter int unsigned NREG     = 32;
  parameter int unsigned REG_AW   = $clog2(NREG);
  parameter int unsigned UOP_MAX  = 20;
  parameter int unsigned CNT_W    = $clog2(UOP_MAX + 1);
  parameter logic [ADDR_W-1:0] CALL_OPC = 16'h940E;

  typedef enum logic [2:0] {
    BS_NONE, BS_PC, BS_SP, BS_MDR, BS_REG, BS_PC_LO, BS_PC_HI
  } bus_src_e;

  typedef enum logic [2:0] {
    BD_NONE, BD_MAR, BD_IR_HI, BD_IR_LO, BD_MDR, BD_REG, BD_PC_HI, BD_PC_LO
  } bus_dst_e;

  typedef struct packed {
    bus_src_e          src;
    bus_dst_e          dst;
    logic [REG_AW-1:0] ra;
    logic              pc_inc;
    logic              sp_dec;
    logic              mem_re;
    logic              mem_we;
  } ctl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ILL} state_e;
endpackage

// File: rtl/call_seq_regfile.sv
module call_seq_regfile
  import call_seq_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned N  = NREG,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] regs_q [N];

  // single port: one address shared by read and write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[addr_i];
endmodule

// File: rtl/call_seq_ctrl.sv
module call_seq_ctrl
  import call_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ir_i,
  output ctl_t              ctl_o,
  output logic              load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic [CNT_W-1:0]  uop_cnt_o
);
  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] uop;
  logic             done_q, ill_q, opc_bad, accept, halt;

  assign uop     = cnt_q + CNT_W'(1);
  assign opc_bad = (ir_i != CALL_OPC);
  assign accept  = start_i && (state_q != ST_RUN);
  assign halt    = (state_q == ST_RUN) && (uop == CNT_W'(7)) && opc_bad;

  always_comb begin
    ctl_o = '0;
    ctl_o.src = BS_NONE;
    ctl_o.dst = BD_NONE;
    if (state_q == ST_RUN && !halt) begin
      unique case (uop)
        CNT_W'(1), CNT_W'(4), CNT_W'(7), CNT_W'(10): begin
          ctl_o.src = BS_PC; ctl_o.dst = BD_MAR; ctl_o.pc_inc = 1'b1;
        end
        CNT_W'(2), CNT_W'(5), CNT_W'(8), CNT_W'(11): ctl_o.mem_re = 1'b1;
        CNT_W'(3):  begin ctl_o.src = BS_MDR; ctl_o.dst = BD_IR_HI; end
        CNT_W'(6):  begin ctl_o.src = BS_MDR; ctl_o.dst = BD_IR_LO; end
        CNT_W'(9):  begin ctl_o.src = BS_MDR; ctl_o.dst = BD_REG; ctl_o.ra = REG_AW'(1); end
        CNT_W'(12): begin ctl_o.src = BS_MDR; ctl_o.dst = BD_REG; ctl_o.ra = REG_AW'(0); end
        CNT_W'(13), CNT_W'(16): begin ctl_o.src = BS_SP; ctl_o.dst = BD_MAR; end
        CNT_W'(14): begin ctl_o.src = BS_PC_LO; ctl_o.dst = BD_MDR; ctl_o.sp_dec = 1'b1; end
        CNT_W'(17): begin ctl_o.src = BS_PC_HI; ctl_o.dst = BD_MDR; ctl_o.sp_dec = 1'b1; end
        CNT_W'(15), CNT_W'(18): ctl_o.mem_we = 1'b1;
        CNT_W'(19): begin ctl_o.src = BS_REG; ctl_o.dst = BD_PC_HI; ctl_o.ra = REG_AW'(1); end
        CNT_W'(20): begin ctl_o.src = BS_REG; ctl_o.dst = BD_PC_LO; ctl_o.ra = REG_AW'(0); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
        ill_q   <= 1'b0;
      end else if (halt) begin
        state_q <= ST_ILL;
        ill_q   <= 1'b1;
      end else if (state_q == ST_RUN) begin
        cnt_q <= uop;
        if (uop == CNT_W'(UOP_MAX)) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign load_o    = accept;
  assign busy_o    = (state_q == ST_RUN);
  assign done_o    = done_q;
  assign illegal_o = ill_q;
  assign uop_cnt_o = cnt_q;

  p_cnt_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_cnt_o <= CNT_W'(UOP_MAX));
  p_done_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> uop_cnt_o == CNT_W'(UOP_MAX));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_ill_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!ctl_o.mem_we && !ctl_o.sp_dec && !busy_o));
  p_busy_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && uop_cnt_o < CNT_W'(6)) |=> (uop_cnt_o == $past(uop_cnt_o) + CNT_W'(1)));
endmodule

// File: rtl/call_seq_dp.sv
module call_seq_dp
  import call_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_pc_i,
  input  logic [ADDR_W-1:0] start_sp_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [ADDR_W-1:0] ir_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o
);
  logic [ADDR_W-1:0] pc_q, sp_q, mar_q, ir_q, bus;
  logic [DATA_W-1:0] mdr_q, rf_rdata;

  always_comb begin
    unique case (ctl_i.src)
      BS_PC:    bus = pc_q;
      BS_SP:    bus = sp_q;
      BS_MDR:   bus = ADDR_W'(mdr_q);
      BS_REG:   bus = ADDR_W'(rf_rdata);
      BS_PC_LO: bus = ADDR_W'(pc_q[DATA_W-1:0]);
      BS_PC_HI: bus = ADDR_W'(pc_q[ADDR_W-1:DATA_W]);
      default:  bus = '0;
    endcase
  end

  call_seq_regfile u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (ctl_i.ra),
    .we_i    (ctl_i.dst == BD_REG),
    .wdata_i (bus[DATA_W-1:0]),
    .rdata_o (rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      sp_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
    end else if (load_i) begin
      pc_q <= start_pc_i;
      sp_q <= start_sp_i;
    end else begin
      if (ctl_i.pc_inc) pc_q <= pc_q + ADDR_W'(1);
      if (ctl_i.sp_dec) sp_q <= sp_q - ADDR_W'(1);
      if (ctl_i.mem_re) mdr_q <= mem_rdata_i;
      unique case (ctl_i.dst)
        BD_MAR:   mar_q <= bus;
        BD_IR_HI: ir_q[ADDR_W-1:DATA_W] <= bus[DATA_W-1:0];
        BD_IR_LO: ir_q[DATA_W-1:0] <= bus[DATA_W-1:0];
        BD_MDR:   mdr_q <= bus[DATA_W-1:0];
        BD_PC_HI: pc_q[ADDR_W-1:DATA_W] <= bus[DATA_W-1:0];
        BD_PC_LO: pc_q[DATA_W-1:0] <= bus[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
  assign ir_o  = ir_q;
  assign pc_o  = pc_q;
  assign sp_o  = sp_q;

  p_push_at_sp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.mem_we |-> (mar_q == sp_q + ADDR_W'(1)));
endmodule

// File: rtl/call_seq_core.sv
module call_seq_core
  import call_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_pc_i,
  input  logic [ADDR_W-1:0] start_sp_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic [CNT_W-1:0]  uop_cnt_o
);
  ctl_t              ctl;
  logic              load;
  logic [ADDR_W-1:0] ir;

  call_seq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ir_i      (ir),
    .ctl_o     (ctl),
    .load_o    (load),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .uop_cnt_o (uop_cnt_o)
  );

  call_seq_dp u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .load_i      (load),
    .start_pc_i  (start_pc_i),
    .start_sp_i  (start_sp_i),
    .mem_rdata_i (mem_rdata_i),
    .mar_o       (mem_addr_o),
    .mdr_o       (mem_wdata_o),
    .ir_o        (ir),
    .pc_o        (pc_o),
    .sp_o        (sp_o)
  );

  assign mem_re_o = ctl.mem_re;
  assign mem_we_o = ctl.mem_we;

  p_mem_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  p_ill_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !start_i) |=> (illegal_o && $stable(sp_o)));
endmodule

// File: tb/sim_call_seq_core.sv
module sim_call_seq_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_pc = '0, start_sp = '0;
  logic [15:0] mem_addr, pc, sp;
  logic        mem_re, mem_we, busy, done, illegal;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [4:0]  uop_cnt;

  int          n_chk = 0, n_fail = 0;
  int          cyc_total = 0;
  logic [7:0]  mem [1024];
  logic [15:0] rd_log [8];
  int          rd_n = 0, wr_n = 0;

  always #10 clk = ~clk;

  call_seq_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .start_pc_i(start_pc), .start_sp_i(start_sp),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc), .sp_o(sp), .busy_o(busy), .done_o(done),
    .illegal_o(illegal), .uop_cnt_o(uop_cnt)
  );

  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    cyc_total++;
    if (mem_we) begin
      mem[mem_addr[9:0]] = mem_wdata;
      wr_n++;
    end
    if (mem_re) begin
      if (rd_n < 8) rd_log[rd_n] = mem_addr;
      rd_n++;
    end
    if (cyc_total > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp<150000", cyc_total);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] ix(input logic [15:0] a);
    return a[9:0];
  endfunction

  task automatic run_call(input logic [15:0] p, input logic [15:0] s,
                          input logic [15:0] tgt, input logic [15:0] opc,
                          input bit poke);
    bit         bad = (opc != 16'h940E);
    int         cyc = 0;
    int         lim = bad ? 7 : 20;
    logic [15:0] ret = p + 16'd4;
    mem[ix(p)]         = opc[15:8];
    mem[ix(p + 16'd1)] = opc[7:0];
    mem[ix(p + 16'd2)] = tgt[15:8];
    mem[ix(p + 16'd3)] = tgt[7:0];
    mem[ix(s)]         = 8'hA5;
    mem[ix(s - 16'd1)] = 8'h5A;
    @(negedge clk);
    start_pc = p; start_sp = s; start = 1'b1;
    rd_n = 0; wr_n = 0;
    @(negedge clk);
    start = 1'b0;
    chk(uop_cnt == 5'd0 && busy, "R8 count cleared at start", {27'd0, uop_cnt}, 0);
    while (!done && !illegal && cyc < 40) begin
      if (poke && cyc == 4) begin
        start_pc = ~p; start_sp = ~s; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (!done) chk(uop_cnt <= 5'd20, "R8 count bound", {27'd0, uop_cnt}, 20);
    end
    start = 1'b0;
    if (bad) begin
      chk(illegal && !busy && cyc == 7, "R3 illegal timing", cyc, 7);
      chk(sp == s, "R3 sp unchanged", {16'd0, sp}, {16'd0, s});
      chk(wr_n == 0 && mem[ix(s)] == 8'hA5 && mem[ix(s - 16'd1)] == 8'h5A,
          "R3 no stack write", wr_n, 0);
      chk(rd_n == 2, "R3 two bytes read", rd_n, 2);
    end else begin
      chk(done && cyc == lim, "R7 done after 20 edges", cyc, lim);
      chk(uop_cnt == 5'd20, "R8 count at done", {27'd0, uop_cnt}, 20);
      chk(pc == tgt, "R6 pc is target", {16'd0, pc}, {16'd0, tgt});
      chk(sp == s - 16'd2, "R5 sp final", {16'd0, sp}, {16'd0, s - 16'd2});
      chk(mem[ix(s)] == ret[7:0], "R4 low byte at sp", {24'd0, mem[ix(s)]}, {24'd0, ret[7:0]});
      chk(mem[ix(s - 16'd1)] == ret[15:8], "R4 high byte at sp-1",
          {24'd0, mem[ix(s - 16'd1)]}, {24'd0, ret[15:8]});
      chk(wr_n == 2, "R10 two writes", wr_n, 2);
      chk(rd_n == 4, "R2 four reads", rd_n, 4);
      for (int k = 0; k < 4; k++)
        chk(rd_log[k] == p + 16'(k), "R2 read order", {16'd0, rd_log[k]}, {16'd0, p + 16'(k)});
      if (poke) chk(pc == tgt && sp == s - 16'd2, "R9 start ignored when busy",
                    {pc, sp}, {tgt, s - 16'd2});
      @(negedge clk);
      chk(!done, "R7 done one cycle", {31'd0, done}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    #35;
    chk(!busy && !done && !illegal && uop_cnt == 5'd0, "R1 reset flags",
        {busy, done, illegal, uop_cnt}, 0);
    chk(pc == 16'd0 && sp == 16'd0, "R1 reset regs", {pc, sp}, 0);
    rst_n = 1'b1;
    // directed corners
    run_call(16'h0100, 16'h0300, 16'hBEEF, 16'h940E, 1'b0);
    run_call(16'hFFFE, 16'h0100, 16'h1234, 16'h940E, 1'b0); // R2 fetch wraps
    run_call(16'h0100, 16'h0000, 16'h4321, 16'h940E, 1'b0); // R5 sp wraps
    run_call(16'h0080, 16'h0280, 16'h0F0F, 16'h940F, 1'b0); // R3 one-bit flip
    run_call(16'h0080, 16'h0280, 16'h0F0F, 16'h9400, 1'b0); // R3 low byte wrong
    run_call(16'h0080, 16'h0280, 16'h0F0F, 16'h140E, 1'b0); // R3 high byte wrong
    run_call(16'h0090, 16'h0290, 16'hA0A0, 16'h940E, 1'b1); // R9 and R3 recovery
    chk(!illegal, "R3 flag cleared by new start", {31'd0, illegal}, 0);
    // random
    for (int t = 0; t < 40; t++) begin
      logic [15:0] p, s, tg, op;
      p  = {6'($urandom), 1'b0, 9'($urandom % 496)};
      s  = {6'($urandom), 1'b1, 9'(2 + $urandom % 500)};
      tg = 16'($urandom);
      op = ($urandom % 4 == 0) ? 16'($urandom) : 16'h940E;
      run_call(p, s, tg, op, ($urandom % 5) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule